// File: doc/BRIEF.md
# Serial Bootloader Command Responder

This block is the device end of a small byte-oriented bootloader protocol. It takes a stream of received bytes, each marked by a one-cycle valid strobe, and answers through a transmit byte stream that a downstream serializer drains with a ready signal. Until the host sends the wake-up byte the block stays silent. After that it serves two commands: an identity query and a memory read. Every command is protected by a complement check, and the read is also gated by a readout-protection option byte.

A memory read collects a big-endian address with an XOR checksum, then a length byte with its complement. It then streams the requested bytes straight from a combinational memory read port, one byte per accepted transfer, at incrementing addresses. Every failed check makes the block send a negative acknowledge and return to the command wait, so the host can retry without waking the block again.

Top module: `boot_cmd_responder`

## Requirements
- R1: After reset, tx_valid and mem_rd are low and the block waits for the wake-up byte.
- R2: Before wake-up, any received byte other than 0x7F produces no transmit byte. The byte 0x7F is answered with ACK (0x79), and the block then waits for commands.
- R3: A command is two bytes: a code and then its bitwise complement. If the second byte is not the complement, the block answers NACK (0x1F).
- R4: A code other than 0x02 or 0x11 that arrives with a correct complement is answered with NACK (0x1F).
- R5: Code 0x02 is answered with three bytes in order: 0x79, 0x04, 0x29.
- R6: prot_level reads 0 when the option byte is 0xAA, 2 when it is 0xCC, and 1 for any other value.
- R7: Code 0x11 is answered with NACK (0x1F), and no ACK before it, unless the option byte is exactly 0xAA. In that case it is answered with ACK.
- R8: After the read ACK, four address bytes arrive most significant first, followed by their XOR. A matching XOR is answered with ACK. A mismatch is answered with NACK.
- R9: The length byte N is followed by ~N. On a match the block sends ACK and then N+1 bytes taken from mem_rdata at addresses that start at the collected address and step by one. On a mismatch it sends NACK.
- R10: mem_rd pulses exactly once for each streamed byte that is accepted. A transmit byte that is offered while tx_ready is low stays unchanged until it is accepted.
- R11: After every NACK and every completed command, the block takes the next command without needing a new wake-up byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Serializer can take a byte this cycle |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_data | output | 8 | Transmit byte |
| prot_opt | input | 8 | Readout-protection option byte |
| prot_level | output | 2 | Decoded protection level (0, 1 or 2) |
| mem_rd | output | 1 | A memory byte is consumed this cycle |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 8 | Memory data for mem_addr, same cycle |

## Verification
The assertions assume a half-duplex host. No byte arrives while a reply or a data stream is still pending, and mem_rdata is valid combinationally for the address being presented. The stimulus respects both assumptions. Before sending further bytes, the driver waits until the scoreboard queue of expected replies is empty. The bench memory model is a pure function of mem_addr. Inside a phase, bytes may arrive back to back. tx_ready is deliberately withheld in a repeating pattern during long streams, which exercises the hold rule without breaking the host assumption.

// File: rtl/bcr_pkg.sv
// Shared constants and types for the bootloader command responder.
// Assumes byte-wide protocol symbols and a 16-bit product identifier.
package bcr_pkg;
    localparam logic [7:0]  BYTE_WAKE   = 8'h7F;
    localparam logic [7:0]  BYTE_ACK    = 8'h79;
    localparam logic [7:0]  BYTE_NACK   = 8'h1F;
    localparam logic [7:0]  CODE_IDENT  = 8'h02;
    localparam logic [7:0]  CODE_FETCH  = 8'h11;
    localparam logic [7:0]  OPT_OPEN    = 8'hAA;
    localparam logic [7:0]  OPT_SEALED  = 8'hCC;
    localparam logic [15:0] PRODUCT_ID  = 16'h0429;

    typedef enum logic [1:0] {
        LVL_OPEN     = 2'd0,
        LVL_READLOCK = 2'd1,
        LVL_SEALED   = 2'd2
    } prot_lvl_t;

    typedef enum logic [3:0] {
        S_ASLEEP,
        S_CODE,
        S_CODE_CK,
        S_ADDR,
        S_LEN,
        S_LEN_CK,
        S_REPLY,
        S_STREAM
    } phase_t;
endpackage

// File: rtl/bcr_prot_decode.sv
// Decodes the readout-protection option byte into a level.
// Assumes the option byte is stable while a command is being judged.
module bcr_prot_decode
    import bcr_pkg::*;
(
    input  logic [7:0] opt_byte,
    output prot_lvl_t  level,
    output logic       is_open
);
    // Exact-match decode; every unlisted value falls into the read-locked level.
    always_comb begin
        if (opt_byte == OPT_OPEN)        level = LVL_OPEN;
        else if (opt_byte == OPT_SEALED) level = LVL_SEALED;
        else                             level = LVL_READLOCK;
        is_open = (opt_byte == OPT_OPEN);
    end
endmodule

// File: rtl/bcr_tx_seq.sv
// Short reply sequencer: loads up to DEPTH bytes at once and offers them
// in order on a valid/ready stream. Assumes load only arrives while idle.
module bcr_tx_seq #(
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DEPTH-1:0][7:0] load_bytes,
    input  logic [CW-1:0]        load_count,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 last_taken
);
    logic [DEPTH-1:0][7:0] buf_q;
    logic [CW-1:0]         left_q;
    logic [CW-1:0]         pos_q;

    // Holds the loaded bytes and walks through them on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            left_q <= '0;
            pos_q  <= '0;
        end else if (load) begin
            buf_q  <= load_bytes;
            left_q <= load_count;
            pos_q  <= '0;
        end else if (out_valid && out_ready) begin
            left_q <= left_q - CW'(1);
            pos_q  <= pos_q + CW'(1);
        end
    end

    // Selects the current byte without indexing past the buffer.
    always_comb begin
        out_valid = (left_q != '0);
        out_data  = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (out_valid && pos_q == CW'(i)) out_data = buf_q[i];
        end
        last_taken = out_valid && out_ready && (left_q == CW'(1));
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)))
        else $error("offered reply byte changed before it was taken");
endmodule

// File: rtl/bcr_addr_collect.sv
// Gathers a big-endian address byte by byte with a running XOR, then acts
// as the incrementing read pointer. Assumes shift and step never coincide.
module bcr_addr_collect #(
    parameter int NBYTES = 4,
    localparam int AW    = 8 * NBYTES,
    localparam int FW    = $clog2(NBYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          shift,
    input  logic [7:0]    shift_byte,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [7:0]    xsum,
    output logic          full
);
    logic [FW-1:0] fill_q;

    // Shifts address bytes in, folds them into the XOR, and counts reads later.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr   <= '0;
            xsum   <= '0;
            fill_q <= '0;
        end else if (shift && !full) begin
            addr   <= {addr[AW-9:0], shift_byte};
            xsum   <= xsum ^ shift_byte;
            fill_q <= fill_q + FW'(1);
        end else if (step) begin
            addr <= addr + AW'(1);
        end
    end

    assign full = (fill_q == FW'(NBYTES));

    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !shift) |=> (addr == $past(addr) + AW'(1)))
        else $error("read pointer did not advance by one");

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FW'(NBYTES))
        else $error("address fill count overran");
endmodule

// File: rtl/boot_cmd_responder.sv
// Device-side bootloader command responder. It sleeps until the wake byte,
// then serves identity and guarded memory-read commands. It assumes a
// half-duplex host (no rx bytes while a reply or stream is pending) and a
// combinational memory port whose data matches mem_addr in the same cycle.
module boot_cmd_responder
    import bcr_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 8,
    localparam int AW        = 8 * ADDR_BYTES,
    localparam int CNT_W     = LEN_W + 1,
    localparam int ID_BYTES  = 2,
    localparam int RESP_MAX  = 1 + ID_BYTES,
    localparam int RCW       = $clog2(RESP_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic [7:0]    prot_opt,
    output logic [1:0]    prot_level,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata
);
    phase_t                   st_q, st_d, ret_q, ret_d;
    logic [7:0]               code_q, code_d;
    logic [LEN_W-1:0]         len_q, len_d;
    logic [CNT_W-1:0]         left_q, left_d;
    logic                     seq_load, seq_valid, seq_last;
    logic [RESP_MAX-1:0][7:0] seq_bytes;
    logic [RCW-1:0]           seq_cnt;
    logic [7:0]               seq_data;
    logic                     col_clear, col_shift, col_full;
    logic [7:0]               col_xsum;
    prot_lvl_t                lvl;
    logic                     lvl_open;
    logic                     streaming;

    bcr_prot_decode i_prot (
        .opt_byte (prot_opt),
        .level    (lvl),
        .is_open  (lvl_open)
    );

    bcr_tx_seq #(.DEPTH(RESP_MAX)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seq_load),
        .load_bytes (seq_bytes),
        .load_count (seq_cnt),
        .out_ready  (tx_ready),
        .out_valid  (seq_valid),
        .out_data   (seq_data),
        .last_taken (seq_last)
    );

    bcr_addr_collect #(.NBYTES(ADDR_BYTES)) i_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (col_clear),
        .shift      (col_shift),
        .shift_byte (rx_data),
        .step       (mem_rd),
        .addr       (mem_addr),
        .xsum       (col_xsum),
        .full       (col_full)
    );

    assign prot_level = lvl;
    assign streaming  = (st_q == S_STREAM);
    assign mem_rd     = streaming && tx_ready;
    assign tx_valid   = seq_valid || streaming;
    assign tx_data    = streaming ? mem_rdata : seq_data;

    // Protocol decisions: judges each received byte and schedules the reply.
    always_comb begin
        st_d      = st_q;
        ret_d     = ret_q;
        code_d    = code_q;
        len_d     = len_q;
        left_d    = left_q;
        seq_load  = 1'b0;
        seq_bytes = '0;
        seq_cnt   = '0;
        col_clear = 1'b0;
        col_shift = 1'b0;
        unique case (st_q)
            S_ASLEEP: begin
                if (rx_valid && rx_data == BYTE_WAKE) begin
                    seq_load = 1'b1; seq_bytes[0] = BYTE_ACK; seq_cnt = RCW'(1);
                    ret_d = S_CODE; st_d = S_REPLY;
                end
            end
            S_CODE: begin
                if (rx_valid) begin
                    code_d = rx_data;
                    st_d   = S_CODE_CK;
                end
            end
            S_CODE_CK: begin
                if (rx_valid) begin
                    seq_load = 1'b1; seq_cnt = RCW'(1); seq_bytes[0] = BYTE_NACK;
                    ret_d = S_CODE; st_d = S_REPLY;
                    if (rx_data == ~code_q) begin
                        if (code_q == CODE_IDENT) begin
                            seq_bytes[0] = BYTE_ACK;
                            for (int i = 0; i < ID_BYTES; i++)
                                seq_bytes[1+i] = PRODUCT_ID[8*(ID_BYTES-1-i) +: 8];
                            seq_cnt = RCW'(RESP_MAX);
                        end else if (code_q == CODE_FETCH && lvl_open) begin
                            seq_bytes[0] = BYTE_ACK;
                            col_clear    = 1'b1;
                            ret_d        = S_ADDR;
                        end
                    end
                end
            end
            S_ADDR: begin
                if (rx_valid) begin
                    if (!col_full) begin
                        col_shift = 1'b1;
                    end else begin
                        seq_load = 1'b1; seq_cnt = RCW'(1); st_d = S_REPLY;
                        if (rx_data == col_xsum) begin
                            seq_bytes[0] = BYTE_ACK;  ret_d = S_LEN;
                        end else begin
                            seq_bytes[0] = BYTE_NACK; ret_d = S_CODE;
                        end
                    end
                end
            end
            S_LEN: begin
                if (rx_valid) begin
                    len_d = rx_data[LEN_W-1:0];
                    st_d  = S_LEN_CK;
                end
            end
            S_LEN_CK: begin
                if (rx_valid) begin
                    seq_load = 1'b1; seq_cnt = RCW'(1); st_d = S_REPLY;
                    if (rx_data[LEN_W-1:0] == ~len_q) begin
                        seq_bytes[0] = BYTE_ACK;
                        ret_d  = S_STREAM;
                        left_d = {1'b0, len_q} + CNT_W'(1);
                    end else begin
                        seq_bytes[0] = BYTE_NACK;
                        ret_d = S_CODE;
                    end
                end
            end
            S_REPLY: begin
                if (seq_last) st_d = ret_q;
            end
            S_STREAM: begin
                if (tx_ready) begin
                    left_d = left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) st_d = S_CODE;
                end
            end
            default: st_d = S_ASLEEP;
        endcase
    end

    // Phase, return phase, latched code, length and remaining-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_ASLEEP;
            ret_q  <= S_CODE;
            code_q <= '0;
            len_q  <= '0;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            ret_q  <= ret_d;
            code_q <= code_d;
            len_q  <= len_d;
            left_q <= left_d;
        end
    end

    p_silent_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ASLEEP && rx_valid && rx_data != BYTE_WAKE) |=> !tx_valid)
        else $error("transmitted while asleep");

    p_read_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CODE_CK && rx_valid && code_q == CODE_FETCH &&
         rx_data == ~CODE_FETCH && prot_opt != OPT_OPEN)
        |=> (tx_valid && tx_data == BYTE_NACK))
        else $error("locked read was not refused first");

    p_stream_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        streaming |-> !seq_valid)
        else $error("reply and stream overlapped");

    p_rd_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (tx_valid && tx_ready))
        else $error("memory consumed without a transfer");
endmodule

// File: tb/test_boot_cmd_responder.sv
module test_boot_cmd_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic [7:0]  prot_opt = 8'h55;
    logic [1:0]  prot_level;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int n_xfer  = 0;
    int n_rd    = 0;
    bit stall_mode = 1'b0;
    bit finished   = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    boot_cmd_responder i_boot_cmd_responder (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .prot_opt(prot_opt), .prot_level(prot_level), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int w = 0;
        while (exp_q.size() != 0 && w < 5000) begin
            @(posedge clk); w++;
        end
        repeat (4) @(posedge clk);
        check({tag, " pending replies"}, exp_q.size(), 0);
    endtask

    // tx_ready driver: always ready, or a repeating stall pattern
    initial begin
        int tick = 0;
        forever begin
            @(posedge clk); #1;
            tick++;
            tx_ready = stall_mode ? ((tick % 3) != 1) : 1'b1;
        end
    end

    // Scoreboard monitor: pops the expected byte for every accepted transfer
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_valid && tx_ready) begin
                n_xfer++;
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R2/R11 unexpected byte actual=%0h expected=none", tx_data);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, tx_data, e);
                end
            end
            if (rst_n && mem_rd) n_rd++;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic do_read(input logic [31:0] a, input logic [7:0] n);
        int rd0;
        logic [7:0] ck;
        prot_opt = 8'hAA;
        expect_byte(8'h79, "R7 open read ack");
        send(8'h11); send(8'hEE);
        drain("R7");
        ck = a[31:24] ^ a[23:16] ^ a[15:8] ^ a[7:0];
        expect_byte(8'h79, "R8 address ack");
        send(a[31:24]); send(a[23:16]); send(a[15:8]); send(a[7:0]); send(ck);
        drain("R8");
        rd0 = n_rd;
        expect_byte(8'h79, "R9 length ack");
        for (int i = 0; i <= n; i++) expect_byte(mem_fn(a + 32'(i)), "R9 stream byte");
        send(n); send(~n);
        drain("R9");
        check("R10 mem_rd count", n_rd - rd0, 32'(n) + 1);
    endtask

    initial begin
        int x0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 tx_valid in reset", tx_valid, 0);
        check("R1 mem_rd in reset", mem_rd, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_valid after reset", tx_valid, 0);

        // R6 decode
        prot_opt = 8'h55; #1 check("R6 level other", prot_level, 1);
        prot_opt = 8'hCC; #1 check("R6 level sealed", prot_level, 2);
        prot_opt = 8'hAA; #1 check("R6 level open", prot_level, 0);
        prot_opt = 8'hAB; #1 check("R6 level near open", prot_level, 1);

        // R2 asleep: ignored bytes, then wake
        x0 = n_xfer;
        send(8'h00); send(8'h02); send(8'hFD); send(8'h11);
        repeat (10) @(posedge clk);
        check("R2 no reply while asleep", n_xfer - x0, 0);
        expect_byte(8'h79, "R2 wake ack");
        send(8'h7F);
        drain("R2");

        // R5 identity
        expect_byte(8'h79, "R5 id ack");
        expect_byte(8'h04, "R5 id high");
        expect_byte(8'h29, "R5 id low");
        send(8'h02); send(8'hFD);
        drain("R5");

        // R3 bad complement, then R11 recovery
        expect_byte(8'h1F, "R3 bad complement nack");
        send(8'h02); send(8'hFC);
        drain("R3");
        expect_byte(8'h79, "R11 id ack after nack");
        expect_byte(8'h04, "R11 id high");
        expect_byte(8'h29, "R11 id low");
        send(8'h02); send(8'hFD);
        drain("R11");

        // R4 unknown code
        expect_byte(8'h1F, "R4 unknown code nack");
        send(8'h44); send(8'hBB);
        drain("R4");

        // R7 locked levels
        prot_opt = 8'h55;
        expect_byte(8'h1F, "R7 read-locked nack");
        send(8'h11); send(8'hEE);
        drain("R7");
        prot_opt = 8'hCC;
        expect_byte(8'h1F, "R7 sealed nack");
        send(8'h11); send(8'hEE);
        drain("R7");

        // R8 R9 short read
        do_read(32'h0000_1000, 8'h03);

        // R8 bad address checksum
        expect_byte(8'h79, "R8 read ack");
        send(8'h11); send(8'hEE);
        drain("R8");
        expect_byte(8'h1F, "R8 bad xor nack");
        send(8'h12); send(8'h34); send(8'h56); send(8'h78); send(8'h00);
        drain("R8");

        // R9 bad length complement
        expect_byte(8'h79, "R9 read ack");
        send(8'h11); send(8'hEE);
        drain("R9");
        expect_byte(8'h79, "R9 addr ack");
        send(8'h00); send(8'h00); send(8'h00); send(8'h40); send(8'h40);
        drain("R9");
        x0 = n_rd;
        expect_byte(8'h1F, "R9 bad length nack");
        send(8'h07); send(8'h07);
        drain("R9");
        check("R9 no memory read on bad length", n_rd - x0, 0);

        // R9 R10 full 256-byte read with stalls
        stall_mode = 1'b1;
        do_read(32'h0800_0000, 8'hFF);
        do_read(32'h0000_FFFE, 8'h04);
        stall_mode = 1'b0;

        // R11 next command after stream
        expect_byte(8'h79, "R11 id ack after stream");
        expect_byte(8'h04, "R11 id high");
        expect_byte(8'h29, "R11 id low");
        send(8'h02); send(8'hFD);
        drain("R11");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule